// File: doc/BRIEF.md
# Ultra DMA Write-Burst Receiver

This block is the device end of an Ultra DMA write burst, where data moves from the host into the device. The host presents a 16-bit word and toggles its strobe line. Both the rising and the falling transition each deliver one word. The receiver brings the strobe and the data into the local clock domain and finds transitions by comparing the synchronized strobe with its value one cycle earlier. Each captured word goes into an elastic FIFO, and the FIFO is drained through a valid/ready stream. A word is taken from the stream only in a cycle where both valid and ready are high. While ready is low, the word and its valid stay unchanged, and that back-pressure is what fills the FIFO.

The receiver drives the active-low ready line toward the host and the transfer-request line. It holds the host off by raising the ready line and lets it go on by lowering it again. After it raises the line, the host may still send one or two words, depending on how long ago its last transition was. The receiver therefore pauses early enough to leave room for them. When the host goes quiet for a set number of cycles without asserting stop, the receiver raises the ready line first and drops the request a fixed number of cycles later. All time values are parameters counted in clock cycles.

Top module: `udma_wr_rx`

## Requirements
- R1: After reset the request output is low, the ready line is high (not ready), the stream output is not valid and the overflow flag is low.
- R2: A start pulse while no burst is active raises the request and lowers the ready line on the next clock edge.
- R3: While a burst is active, every transition of the strobe (low-to-high or high-to-low) captures the data input as one word, and the words leave the stream in arrival order. Transitions while no burst is active store nothing.
- R4: A word offered on the stream keeps valid high and its data unchanged until it is taken with ready high.
- R5: The receiver never pauses before the first word of the current burst has arrived, even when the FIFO has less free room than the reserve.
- R6: After the first word, the ready line is raised when the free FIFO entries fall to or below the reserve. The reserve is 1 while no more than TSR_CYC cycles have passed since the last strobe transition, and 2 after that.
- R7: A paused receiver lowers the ready line again once the free entries exceed the reserve.
- R8: If no strobe transition arrives for TIDLE_CYC cycles while the receiver is running and stop is low, the ready line goes high while the request stays high. The request then falls exactly TRP_CYC cycles later.
- R9: Stop asserted during a burst ends it: on the next edge the request is low and the ready line is high.
- R10: A word that arrives while the FIFO is full and no word leaves in that cycle is discarded and sets the overflow flag. The flag stays set until the next start. A word that arrives in the same cycle as a word leaves a full FIFO is stored and does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_start_i | input | 1 | Pulse that opens a burst (honoured only while idle) |
| host_stop_i | input | 1 | Host request to end the burst |
| wr_strobe_i | input | 1 | Host data strobe, asynchronous, both transitions significant |
| wr_data_i | input | DW | Host data word, stable around each strobe transition |
| xfer_req_o | output | 1 | Transfer request toward the host |
| dev_ready_n_o | output | 1 | Active-low ready line toward the host |
| word_valid_o | output | 1 | Stream word available |
| word_data_o | output | DW | Stream word |
| word_ready_i | input | 1 | Stream consumer accepts the word |
| overflow_o | output | 1 | Sticky flag: a word was lost to a full FIFO |

## Verification
A word can arrive from the strobe in the same cycle as the stream takes a word out of a full FIFO. That cycle decides whether the arriving word is kept or counted as an overflow. The bench fills the FIFO, makes one strobe transition, and raises the stream ready exactly for the edge on which the synchronized transition is pushed, two cycles after the transition. It then expects the overflow flag to stay low and the drained sequence to end with the late word, with the oldest word gone. A second test sends a word into a full FIFO with no word leaving, and expects the flag to go high and the word to be missing from the drained data.

// File: rtl/udma_rx_pkg.sv
package udma_rx_pkg;
  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_PAUSED    = 2'd1,
    ST_TERM_WAIT = 2'd2,
    ST_DONE      = 2'd3
  } rx_state_e;
endpackage

// File: rtl/udma_rx_strobe_sync.sv
module udma_rx_strobe_sync #(
  parameter int DW     = 16,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_i,
  input  logic [DW-1:0] data_i,
  output logic          edge_o,
  output logic [DW-1:0] data_o
);
  logic [STAGES-1:0] strb_q;
  logic [DW-1:0]     data_q [STAGES];
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          strb_q[g] <= 1'b0;
          data_q[g] <= '0;
        end else if (g == 0) begin
          strb_q[g] <= strobe_i;
          data_q[g] <= data_i;
        end else begin
          strb_q[g] <= strb_q[(g > 0) ? g-1 : 0];
          data_q[g] <= data_q[(g > 0) ? g-1 : 0];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= strb_q[STAGES-1];
  end

  assign edge_o = strb_q[STAGES-1] ^ prev_q;
  assign data_o = data_q[STAGES-1];
endmodule

// File: rtl/udma_rx_fifo.sv
module udma_rx_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [DW-1:0]              push_data_i,
  output logic                       valid_o,
  output logic [DW-1:0]              data_o,
  input  logic                       ready_i,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       full_o,
  output logic                       pop_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign valid_o = (count_q != '0);
  assign full_o  = (count_q == CW'(DEPTH));
  assign pop_o   = valid_o && ready_i;
  assign data_o  = mem[rd_ptr];
  assign count_o = count_q;

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_o)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_i, pop_o})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/udma_rx_ctrl.sv
module udma_rx_ctrl
  import udma_rx_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int TSR_CYC   = 4,
  parameter int TIDLE_CYC = 40,
  parameter int TRP_CYC   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       stop_i,
  input  logic                       edge_i,
  input  logic [$clog2(DEPTH+1)-1:0] fifo_count_i,
  input  logic                       fifo_full_i,
  input  logic                       pop_i,
  output logic                       push_o,
  output logic                       overflow_o,
  output logic                       rdy_n_o,
  output logic                       dmarq_o,
  output rx_state_e                  state_o,
  output logic                       got_word_o
);
  localparam int CW        = $clog2(DEPTH+1);
  localparam int SINCE_MAX = TSR_CYC + 1;
  localparam int SW        = $clog2(SINCE_MAX+1);
  localparam int IW        = $clog2(TIDLE_CYC+1);
  localparam int TW        = $clog2(TRP_CYC+1);

  rx_state_e     state_q, state_d;
  logic [SW-1:0] since_q;
  logic [IW-1:0] idle_q;
  logic [TW-1:0] trp_q;
  logic          got_word_q, ovf_q, rdy_n_q, dmarq_q;

  logic [CW-1:0] free_ent, reserve;
  logic          need_pause, accept, drop, timeout, open_burst;

  always_comb begin
    free_ent   = CW'(DEPTH) - fifo_count_i;
    reserve    = (since_q <= SW'(TSR_CYC)) ? CW'(1) : CW'(2);
    need_pause = got_word_q && (free_ent <= reserve);
    accept     = edge_i && (state_q != ST_DONE);
    push_o     = accept && (!fifo_full_i || pop_i);
    drop       = accept && fifo_full_i && !pop_i;
    timeout    = (state_q == ST_RUN) && !edge_i && (idle_q == IW'(TIDLE_CYC-1));
    open_burst = (state_q == ST_DONE) && start_i;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_DONE: if (start_i) state_d = ST_RUN;
      ST_RUN: begin
        if (stop_i)          state_d = ST_DONE;
        else if (timeout)    state_d = ST_TERM_WAIT;
        else if (need_pause) state_d = ST_PAUSED;
      end
      ST_PAUSED: begin
        if (stop_i)           state_d = ST_DONE;
        else if (!need_pause) state_d = ST_RUN;
      end
      ST_TERM_WAIT: begin
        if (stop_i || (trp_q == TW'(TRP_CYC-1))) state_d = ST_DONE;
      end
      default: state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_DONE;
      rdy_n_q    <= 1'b1;
      dmarq_q    <= 1'b0;
      since_q    <= '0;
      idle_q     <= '0;
      trp_q      <= '0;
      got_word_q <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      rdy_n_q <= (state_d != ST_RUN);
      dmarq_q <= (state_d != ST_DONE);

      if (accept || open_burst)              since_q <= '0;
      else if (since_q != SW'(SINCE_MAX))    since_q <= since_q + SW'(1);

      if ((state_q != ST_RUN) || edge_i)         idle_q <= '0;
      else if (idle_q != IW'(TIDLE_CYC-1))       idle_q <= idle_q + IW'(1);

      if (state_q != ST_TERM_WAIT) trp_q <= '0;
      else                         trp_q <= trp_q + TW'(1);

      if (open_burst)  got_word_q <= 1'b0;
      else if (accept) got_word_q <= 1'b1;

      if (open_burst) ovf_q <= 1'b0;
      else if (drop)  ovf_q <= 1'b1;
    end
  end

  assign overflow_o = ovf_q;
  assign rdy_n_o    = rdy_n_q;
  assign dmarq_o    = dmarq_q;
  assign state_o    = state_q;
  assign got_word_o = got_word_q;
endmodule

// File: rtl/udma_wr_rx.sv
module udma_wr_rx
  import udma_rx_pkg::*;
#(
  parameter int DW          = 16,
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TSR_CYC     = 4,
  parameter int TIDLE_CYC   = 40,
  parameter int TRP_CYC     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          burst_start_i,
  input  logic          host_stop_i,
  input  logic          wr_strobe_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          xfer_req_o,
  output logic          dev_ready_n_o,
  output logic          word_valid_o,
  output logic [DW-1:0] word_data_o,
  input  logic          word_ready_i,
  output logic          overflow_o
);
  localparam int CW = $clog2(DEPTH+1);

  logic          strb_edge;
  logic [DW-1:0] cap_data;
  logic          push, pop, fifo_full;
  logic [CW-1:0] fifo_count;
  rx_state_e     state;
  logic          got_word;

  udma_rx_strobe_sync #(.DW(DW), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .strobe_i(wr_strobe_i), .data_i(wr_data_i),
    .edge_o(strb_edge), .data_o(cap_data)
  );

  udma_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_i(push), .push_data_i(cap_data),
    .valid_o(word_valid_o), .data_o(word_data_o), .ready_i(word_ready_i),
    .count_o(fifo_count), .full_o(fifo_full), .pop_o(pop)
  );

  udma_rx_ctrl #(.DEPTH(DEPTH), .TSR_CYC(TSR_CYC), .TIDLE_CYC(TIDLE_CYC),
                 .TRP_CYC(TRP_CYC)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_i(burst_start_i), .stop_i(host_stop_i),
    .edge_i(strb_edge), .fifo_count_i(fifo_count),
    .fifo_full_i(fifo_full), .pop_i(pop),
    .push_o(push), .overflow_o(overflow_o),
    .rdy_n_o(dev_ready_n_o), .dmarq_o(xfer_req_o),
    .state_o(state), .got_word_o(got_word)
  );
endmodule

// File: rtl/udma_wr_rx_chk.sv
module udma_wr_rx_chk
  import udma_rx_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start_i,
  input logic                       dmarq,
  input logic                       rdy_n,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [DW-1:0]              out_data,
  input rx_state_e                  state,
  input logic                       got_word,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count
);
  a_r1_idle_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !dmarq |-> rdy_n);

  a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && start_i) |=> (dmarq && !rdy_n));

  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r5_no_early_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAUSED) |-> got_word);

  a_r8_ready_before_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dmarq) |-> rdy_n);

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind udma_wr_rx udma_wr_rx_chk #(.DW(DW), .DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .start_i(burst_start_i),
  .dmarq(xfer_req_o), .rdy_n(dev_ready_n_o),
  .out_valid(word_valid_o), .out_ready(word_ready_i), .out_data(word_data_o),
  .state(state), .got_word(got_word), .fifo_count(fifo_count)
);

// File: tb/test_udma_wr_rx.sv
`timescale 1ns/1ps
module test_udma_wr_rx;
  localparam int DW = 16, DEPTH = 8, TSR = 4, TIDLE = 40, TRP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, strobe = 1'b0, wready = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic dmarq, rdy_n, wvalid, ovf;
  logic [DW-1:0] rdata;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  udma_wr_rx #(.DW(DW), .DEPTH(DEPTH), .TSR_CYC(TSR), .TIDLE_CYC(TIDLE),
               .TRP_CYC(TRP)) i_udma_wr_rx (
    .clk(clk), .rst_n(rst_n), .burst_start_i(start), .host_stop_i(stop),
    .wr_strobe_i(strobe), .wr_data_i(wdata), .xfer_req_o(dmarq),
    .dev_ready_n_o(rdy_n), .word_valid_o(wvalid), .word_data_o(rdata),
    .word_ready_i(wready), .overflow_o(ovf)
  );

  function automatic logic [15:0] wv(input int i);
    return 16'hA500 ^ 16'(i * 4951);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [15:0] v);
    @(negedge clk);
    wdata  = v;
    strobe = ~strobe;
    repeat (3) @(negedge clk);
  endtask

  task automatic pop_check(input logic [15:0] exp, input int stall, input string tag);
    for (int s = 0; s < stall; s++) begin
      chk(wvalid === 1'b1 && rdata === exp, "R4 stalled word held", int'(rdata), int'(exp));
      @(negedge clk);
    end
    chk(wvalid === 1'b1 && rdata === exp, tag, int'(rdata), int'(exp));
    wready = 1'b1;
    @(negedge clk);
    wready = 1'b0;
  endtask

  task automatic drain(input int base, input int n);
    for (int i = 0; i < n; i++) pop_check(wv(base + i), i % 3, "R3 word order");
  endtask

  task automatic open_burst();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cnt;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(dmarq === 1'b0, "R1 request low", int'(dmarq), 0);
    chk(rdy_n === 1'b1, "R1 ready negated", int'(rdy_n), 1);
    chk(wvalid === 1'b0 && ovf === 1'b0, "R1 stream/overflow idle", int'({wvalid, ovf}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 strobes while idle store nothing
    send_word(16'h1111);
    send_word(16'h2222);
    chk(wvalid === 1'b0, "R3 idle strobe ignored", int'(wvalid), 0);

    // R2 open burst
    open_burst();
    chk(dmarq === 1'b1 && rdy_n === 1'b0, "R2 burst opened", int'({dmarq, rdy_n}), 2);

    // R6/R7 sweep over fill level and reserve
    for (int k = 1; k <= DEPTH; k++) begin
      send_word(wv(k - 1));
      @(negedge clk);
      chk(rdy_n === ((DEPTH - k) <= 1), "R6 reserve one after recent edge",
          int'(rdy_n), int'((DEPTH - k) <= 1));
      repeat (TSR + 1) @(negedge clk);
      chk(rdy_n === ((DEPTH - k) <= 2), "R6 reserve two after quiet strobe",
          int'(rdy_n), int'((DEPTH - k) <= 2));
    end

    // R10 word into full FIFO is dropped
    send_word(16'hDEAD);
    chk(ovf === 1'b1, "R10 overflow set", int'(ovf), 1);
    drain(0, DEPTH);
    chk(wvalid === 1'b0, "R10 dropped word absent", int'(wvalid), 0);
    repeat (2) @(negedge clk);
    chk(rdy_n === 1'b0, "R7 resumed after drain", int'(rdy_n), 0);
    chk(ovf === 1'b1, "R10 overflow sticky", int'(ovf), 1);

    // R8 idle termination ordering and delay
    cnt = 0;
    while (rdy_n !== 1'b1 && cnt < 200) begin @(negedge clk); cnt++; end
    chk(dmarq === 1'b1, "R8 request held when ready negated", int'(dmarq), 1);
    cnt = 0;
    while (dmarq === 1'b1 && cnt < 200) begin @(negedge clk); cnt++; end
    chk(cnt == TRP, "R8 request drop delay", cnt, TRP);

    // R10 simultaneous push and pop on a full FIFO
    open_burst();
    chk(ovf === 1'b0, "R10 overflow cleared by start", int'(ovf), 0);
    for (int k = 0; k < DEPTH; k++) send_word(wv(k));
    chk(rdy_n === 1'b1, "R6 paused at full", int'(rdy_n), 1);
    @(negedge clk); wdata = 16'hBEEF; strobe = ~strobe;
    @(negedge clk);
    @(negedge clk); wready = 1'b1;
    @(negedge clk); wready = 1'b0;
    chk(ovf === 1'b0, "R10 no overflow on same-cycle pop", int'(ovf), 0);
    drain(1, DEPTH - 1);
    pop_check(16'hBEEF, 1, "R10 late word kept");

    // R9 stop ends burst
    for (int k = 0; k < DEPTH - 1; k++) send_word(wv(20 + k));
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk(dmarq === 1'b0 && rdy_n === 1'b1, "R9 stop ends burst", int'({dmarq, rdy_n}), 1);

    // R5 no pause before first word despite little room
    open_burst();
    chk(rdy_n === 1'b0, "R5 ready with leftovers", int'(rdy_n), 0);
    repeat (TSR + 2) @(negedge clk);
    chk(rdy_n === 1'b0, "R5 still ready before first word", int'(rdy_n), 0);
    send_word(16'h5A5A);
    @(negedge clk);
    chk(rdy_n === 1'b1, "R6 paused after first word", int'(rdy_n), 1);
    chk(ovf === 1'b0, "R10 no overflow", int'(ovf), 0);
    drain(20, DEPTH - 1);
    pop_check(16'h5A5A, 0, "R3 last word");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule